// File: doc/BRIEF.md
# Snoop Inquire Cycle Controller

This block is the system-side sequencer that probes a processor's cache for another bus master. A request carries the line address and a flag saying whether the processor's copy should be invalidated. The controller takes the processor's address bus with one of three hold mechanisms and presents the snoop address with a single-cycle strobe. It then reads the processor's hit and hit-modified replies a fixed number of cycles later. On a hit to a modified line it waits for the processor's writeback to complete.

It ends with a one-cycle completion pulse. The pulse carries the coherence state the requesting master may install the line in, and, in look-aside configuration, a memory-inhibit flag so that main memory stays silent when the L2 holds the line. One cycle later the hold is released. Configuration inputs pick the hold mechanism and the cache topology. They are captured when a request is accepted and stay fixed for that inquire.

Top module: `snoop_inquire_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, all hold outputs, `snp_strobe_o`, `snp_inv_o`, `done_o`, `grant_o` and `mem_inhibit_o` are low. A request presented during reset starts nothing.
- R2: From the cycle after a request is accepted in the idle state, exactly one hold output is high. If `cfg_legacy` is 1 it is `hold_bus_o`. Otherwise it is `hold_backoff_o` when `cfg_backoff` is 1, or `hold_addr_o` when `cfg_backoff` is 0.
- R3: With the fast holds, the snoop strobe rises in the second cycle after acceptance. With bus-hold, the strobe rises only in the cycle after an edge at which `hold_ack_i` was sampled high.
- R4: `snp_strobe_o` is high for exactly one cycle, while a hold is asserted. In that cycle `snp_addr_o` equals the accepted address and `snp_inv_o` equals the accepted invalidate flag.
- R5: `cpu_hit_i`, `cpu_hitm_i` and `l2_hit_i` are sampled only at the edge that ends the cycle `SAMPLE_DLY` cycles after the strobe cycle (default 2). Their values in other cycles have no effect.
- R6: With `cfg_lookthrough` = 0 (look-aside), the grant code is always 01 (shared), whatever `cpu_hit_i` reports.
- R7: With `cfg_lookthrough` = 1, the grant code is 10 (exclusive) when `cpu_hit_i` was sampled low, and 01 (shared) when it was sampled high.
- R8: If `cpu_hitm_i` was sampled high, `done_o` stays low until the cycle after an edge at which `wb_done_i` is high. Otherwise `done_o` rises in the cycle right after the sample edge.
- R9: `done_o` is a one-cycle pulse. `grant_o` carries the grant code in that cycle and is 00 in every other cycle.
- R10: `mem_inhibit_o` is high only in the `done_o` cycle. It is high there exactly when the mode is look-aside and `l2_hit_i` was sampled high.
- R11: All hold outputs drop in the cycle after `done_o`, and the controller is idle the cycle after that. Requests presented while an inquire is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Inquire request, accepted when idle |
| req_addr | input | ADDR_W | Line address to probe |
| req_inv | input | 1 | Invalidate the processor's copy |
| cfg_legacy | input | 1 | Use the slow bus-hold mechanism |
| cfg_backoff | input | 1 | Fast mode: 1 back-off, 0 address-hold |
| cfg_lookthrough | input | 1 | 1 look-through L2, 0 look-aside L2 |
| hold_ack_i | input | 1 | Bus-hold acknowledge from the processor |
| cpu_hit_i | input | 1 | Processor reports a hit |
| cpu_hitm_i | input | 1 | Processor reports a hit to a modified line |
| wb_done_i | input | 1 | Processor writeback finished |
| l2_hit_i | input | 1 | Look-aside L2 holds the line |
| hold_addr_o | output | 1 | Address-hold request |
| hold_backoff_o | output | 1 | Back-off request |
| hold_bus_o | output | 1 | Bus-hold request |
| snp_strobe_o | output | 1 | Snoop address strobe |
| snp_addr_o | output | ADDR_W | Snoop address |
| snp_inv_o | output | 1 | Invalidate qualifier with the strobe |
| done_o | output | 1 | Inquire complete pulse |
| grant_o | output | 2 | 00 none, 01 shared, 10 exclusive |
| mem_inhibit_o | output | 1 | Tell memory not to respond |

## Verification
On every cycle the assertions check these properties:
- at most one hold is active, and bus-hold appears only in legacy mode;
- the strobe and the completion pulse each last one cycle, and the strobe occurs only under a hold;
- the grant code is zero outside the completion pulse, and look-aside always grants shared;
- memory inhibit never shows outside a look-aside completion;
- no completion appears while a writeback is still outstanding;
- the hold drops right after completion.

Only the directed scenarios can show the cycle at which replies are sampled. They drive misleading hit values in the neighbouring cycles. The scenarios also cover the exclusive-versus-shared choice in look-through mode, the wait for the bus-hold acknowledge, the exact writeback delay, and that a request arriving mid-inquire is dropped.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ACQUIRE, ST_SNOOP, ST_SAMPLE, ST_WAIT_WB, ST_GRANT, ST_RELEASE
  } snp_state_e;

  typedef enum logic [1:0] {
    HOLD_ADDR    = 2'd0,
    HOLD_BACKOFF = 2'd1,
    HOLD_BUS     = 2'd2
  } hold_sel_e;

  localparam int NUM_HOLDS = 3;

  localparam logic [1:0] GR_NONE   = 2'b00;
  localparam logic [1:0] GR_SHARED = 2'b01;
  localparam logic [1:0] GR_EXCL   = 2'b10;
endpackage

// File: rtl/snp_hold_sel.sv
module snp_hold_sel
  import snp_pkg::*;
(
  input  logic                 cfg_legacy,
  input  logic                 cfg_backoff,
  input  hold_sel_e            sel_q,
  input  logic                 use_cfg,
  input  logic                 active,
  output hold_sel_e            sel,
  output logic [NUM_HOLDS-1:0] hold_vec
);
  hold_sel_e sel_cfg;

  always_comb begin
    if (cfg_legacy)       sel_cfg = HOLD_BUS;
    else if (cfg_backoff) sel_cfg = HOLD_BACKOFF;
    else                  sel_cfg = HOLD_ADDR;
  end

  assign sel = use_cfg ? sel_cfg : sel_q;

  for (genvar i = 0; i < NUM_HOLDS; i++) begin : g_hold
    assign hold_vec[i] = active && (sel == hold_sel_e'(i));
  end
endmodule

// File: rtl/snp_grant_calc.sv
module snp_grant_calc
  import snp_pkg::*;
(
  input  logic       lookthrough,
  input  logic       hit,
  input  logic       l2_hit,
  output logic [1:0] grant,
  output logic       inhibit
);
  always_comb begin
    if (lookthrough) grant = hit ? GR_SHARED : GR_EXCL;
    else             grant = GR_SHARED;
    inhibit = !lookthrough && l2_hit;
  end
endmodule

// File: rtl/snp_seq.sv
module snp_seq
  import snp_pkg::*;
#(
  parameter int SAMPLE_DLY = 2,
  localparam int CNT_W = $clog2(SAMPLE_DLY + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       legacy,
  input  logic       hold_ack,
  input  logic       hitm,
  input  logic       wb_done,
  output snp_state_e state,
  output snp_state_e nxt,
  output logic       sample_now
);
  logic [CNT_W-1:0] cnt;

  assign sample_now = (state == ST_SAMPLE) && (cnt == CNT_W'(SAMPLE_DLY));

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:    if (req_valid) nxt = ST_ACQUIRE;
      ST_ACQUIRE: if (!legacy || hold_ack) nxt = ST_SNOOP;
      ST_SNOOP:   nxt = ST_SAMPLE;
      ST_SAMPLE:  if (sample_now) nxt = hitm ? ST_WAIT_WB : ST_GRANT;
      ST_WAIT_WB: if (wb_done) nxt = ST_GRANT;
      ST_GRANT:   nxt = ST_RELEASE;
      ST_RELEASE: nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (state == ST_SNOOP)      cnt <= CNT_W'(1);
      else if (state == ST_SAMPLE) cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/snoop_inquire_ctrl.sv
module snoop_inquire_ctrl
  import snp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SAMPLE_DLY = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_inv,
  input  logic              cfg_legacy,
  input  logic              cfg_backoff,
  input  logic              cfg_lookthrough,
  input  logic              hold_ack_i,
  input  logic              cpu_hit_i,
  input  logic              cpu_hitm_i,
  input  logic              wb_done_i,
  input  logic              l2_hit_i,
  output logic              hold_addr_o,
  output logic              hold_backoff_o,
  output logic              hold_bus_o,
  output logic              snp_strobe_o,
  output logic [ADDR_W-1:0] snp_addr_o,
  output logic              snp_inv_o,
  output logic              done_o,
  output logic [1:0]        grant_o,
  output logic              mem_inhibit_o
);
  snp_state_e state, nxt;
  logic       sample_now;
  logic       accept;
  logic       inv_q, lt_q, legacy_q;
  hold_sel_e  sel_q, sel;
  logic [NUM_HOLDS-1:0] hold_vec;
  logic       hold_active_nxt;
  logic [1:0] grant_calc, grant_pend, grant_nxt;
  logic       inh_calc, inh_pend, inh_nxt;
  logic       in_wb;

  assign accept = (state == ST_IDLE) && req_valid;
  assign in_wb  = (state == ST_WAIT_WB);

  snp_seq #(.SAMPLE_DLY(SAMPLE_DLY)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .legacy(legacy_q),
    .hold_ack(hold_ack_i), .hitm(cpu_hitm_i), .wb_done(wb_done_i),
    .state(state), .nxt(nxt), .sample_now(sample_now)
  );

  assign hold_active_nxt = (nxt != ST_IDLE) && (nxt != ST_RELEASE);

  snp_hold_sel u_hold (
    .cfg_legacy(cfg_legacy), .cfg_backoff(cfg_backoff), .sel_q(sel_q),
    .use_cfg(accept), .active(hold_active_nxt), .sel(sel), .hold_vec(hold_vec)
  );

  snp_grant_calc u_grant (
    .lookthrough(lt_q), .hit(cpu_hit_i), .l2_hit(l2_hit_i),
    .grant(grant_calc), .inhibit(inh_calc)
  );

  assign grant_nxt = sample_now ? grant_calc : grant_pend;
  assign inh_nxt   = sample_now ? inh_calc   : inh_pend;

  // Request capture
  always_ff @(posedge clk) begin
    if (rst) begin
      snp_addr_o <= '0;
      inv_q      <= 1'b0;
      lt_q       <= 1'b0;
      legacy_q   <= 1'b0;
      sel_q      <= HOLD_ADDR;
    end else if (accept) begin
      snp_addr_o <= req_addr;
      inv_q      <= req_inv;
      lt_q       <= cfg_lookthrough;
      legacy_q   <= cfg_legacy;
      sel_q      <= sel;
    end
  end

  // Sampled snoop result
  always_ff @(posedge clk) begin
    if (rst) begin
      grant_pend <= GR_NONE;
      inh_pend   <= 1'b0;
    end else if (sample_now) begin
      grant_pend <= grant_calc;
      inh_pend   <= inh_calc;
    end
  end

  // Registered outputs decoded from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_addr_o    <= 1'b0;
      hold_backoff_o <= 1'b0;
      hold_bus_o     <= 1'b0;
      snp_strobe_o   <= 1'b0;
      snp_inv_o      <= 1'b0;
      done_o         <= 1'b0;
      grant_o        <= GR_NONE;
      mem_inhibit_o  <= 1'b0;
    end else begin
      hold_addr_o    <= hold_vec[HOLD_ADDR];
      hold_backoff_o <= hold_vec[HOLD_BACKOFF];
      hold_bus_o     <= hold_vec[HOLD_BUS];
      snp_strobe_o   <= (nxt == ST_SNOOP);
      snp_inv_o      <= (nxt == ST_SNOOP) && inv_q;
      done_o         <= (nxt == ST_GRANT);
      grant_o        <= (nxt == ST_GRANT) ? grant_nxt : GR_NONE;
      mem_inhibit_o  <= (nxt == ST_GRANT) && inh_nxt;
    end
  end
endmodule

// File: rtl/snp_checker.sv
module snp_checker (
  input logic       clk,
  input logic       rst,
  input logic       hold_addr_o,
  input logic       hold_backoff_o,
  input logic       hold_bus_o,
  input logic       snp_strobe_o,
  input logic       done_o,
  input logic [1:0] grant_o,
  input logic       mem_inhibit_o,
  input logic       wb_done_i,
  input logic       lt_q,
  input logic       legacy_q,
  input logic       in_wb
);
  logic any_hold;
  assign any_hold = hold_addr_o || hold_backoff_o || hold_bus_o;

  p_one_hold_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hold_addr_o, hold_backoff_o, hold_bus_o}));
  p_bus_hold_legacy_r2: assert property (@(posedge clk) disable iff (rst)
    hold_bus_o |-> legacy_q);
  p_strobe_held_r4: assert property (@(posedge clk) disable iff (rst)
    snp_strobe_o |-> any_hold);
  p_strobe_single_r4: assert property (@(posedge clk) disable iff (rst)
    snp_strobe_o |=> !snp_strobe_o);
  p_lookaside_shared_r6: assert property (@(posedge clk) disable iff (rst)
    (done_o && !lt_q) |-> (grant_o == 2'b01));
  p_wb_outstanding_r8: assert property (@(posedge clk) disable iff (rst)
    (in_wb && !wb_done_i) |=> !done_o);
  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_grant_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> (grant_o == 2'b00));
  p_grant_code_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (grant_o == 2'b01 || grant_o == 2'b10));
  p_inhibit_scope_r10: assert property (@(posedge clk) disable iff (rst)
    mem_inhibit_o |-> (done_o && !lt_q));
  p_release_r11: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !any_hold);
endmodule

bind snoop_inquire_ctrl snp_checker u_chk (
  .clk(clk), .rst(rst), .hold_addr_o(hold_addr_o), .hold_backoff_o(hold_backoff_o),
  .hold_bus_o(hold_bus_o), .snp_strobe_o(snp_strobe_o), .done_o(done_o),
  .grant_o(grant_o), .mem_inhibit_o(mem_inhibit_o), .wb_done_i(wb_done_i),
  .lt_q(lt_q), .legacy_q(legacy_q), .in_wb(in_wb)
);

// File: tb/tb_snoop_inquire_ctrl.sv
`timescale 1ns/1ps
module tb_snoop_inquire_ctrl;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_inv = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic cfg_legacy = 0, cfg_backoff = 0, cfg_lookthrough = 0;
  logic hold_ack_i = 0, cpu_hit_i = 0, cpu_hitm_i = 0, wb_done_i = 0, l2_hit_i = 0;
  logic hold_addr_o, hold_backoff_o, hold_bus_o, snp_strobe_o, snp_inv_o;
  logic done_o, mem_inhibit_o;
  logic [ADDR_W-1:0] snp_addr_o;
  logic [1:0] grant_o;

  int checks = 0;
  int fails  = 0;
  int seq_no = 0;

  always #10 clk = ~clk;

  snoop_inquire_ctrl #(.ADDR_W(ADDR_W), .SAMPLE_DLY(2)) dut (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] holds();
    return {hold_bus_o, hold_backoff_o, hold_addr_o};
  endfunction

  task automatic check_reset();
    req_valid = 1'b1;
    repeat (3) @(negedge clk);
    check(holds() == 3'b000 && !snp_strobe_o && !snp_inv_o, "R1 holds/strobe in reset",
          {holds(), snp_strobe_o}, 0);
    check(!done_o && grant_o == 2'b00 && !mem_inhibit_o, "R1 done/grant in reset",
          {done_o, grant_o, mem_inhibit_o}, 0);
    req_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check(holds() == 3'b000 && !snp_strobe_o && !done_o, "R1 first cycle after reset",
          {holds(), snp_strobe_o, done_o}, 0);
  endtask

  task automatic run_snoop(input logic legacy, backoff, lt, inv, hit, hitm, l2hit,
                           input int wb_wait, input logic [1:0] exp_gr, input logic exp_inh);
    logic [2:0] exp_hold;
    logic [ADDR_W-1:0] a;
    exp_hold = legacy ? 3'b100 : (backoff ? 3'b010 : 3'b001);
    a = 32'h1000_0040 + ADDR_W'(seq_no * 64);
    seq_no++;
    @(negedge clk);
    cfg_legacy = legacy; cfg_backoff = backoff; cfg_lookthrough = lt;
    req_valid = 1'b1; req_addr = a; req_inv = inv;
    @(negedge clk);
    req_valid = 1'b0; req_inv = !inv; req_addr = ~a;
    cfg_legacy = !legacy; cfg_backoff = !backoff; cfg_lookthrough = !lt;
    check(holds() == exp_hold, "R2 hold selection", holds(), exp_hold);
    check(!snp_strobe_o, "R3 no strobe in acquire", snp_strobe_o, 0);
    if (legacy) begin
      for (int i = 0; i < 2; i++) begin
        @(negedge clk);
        check(!snp_strobe_o, "R3 strobe waits for bus-hold ack", snp_strobe_o, 0);
      end
      hold_ack_i = 1'b1;
    end
    @(negedge clk);
    hold_ack_i = 1'b0;
    check(snp_strobe_o, "R3 strobe timing", snp_strobe_o, 1);
    check(snp_addr_o == a, "R4 snoop address", snp_addr_o, a);
    check(snp_inv_o == inv, "R4 invalidate flag", snp_inv_o, inv);
    check(holds() == exp_hold, "R4 strobe under hold", holds(), exp_hold);
    cpu_hit_i = !hit; cpu_hitm_i = !hitm; l2_hit_i = !l2hit;
    @(negedge clk);
    check(!snp_strobe_o && !snp_inv_o, "R4 strobe one cycle", snp_strobe_o, 0);
    @(negedge clk);
    cpu_hit_i = hit; cpu_hitm_i = hitm; l2_hit_i = l2hit;
    @(negedge clk);
    cpu_hit_i = !hit; cpu_hitm_i = !hitm; l2_hit_i = !l2hit;
    if (hitm) begin
      check(!done_o, "R8 done held for writeback", done_o, 0);
      for (int i = 0; i < wb_wait; i++) begin
        @(negedge clk);
        check(!done_o, "R8 done held for writeback", done_o, 0);
      end
      wb_done_i = 1'b1;
      @(negedge clk);
      wb_done_i = 1'b0;
    end
    check(done_o, "R5/R8 done timing", done_o, 1);
    check(grant_o == exp_gr, lt ? "R7 look-through grant" : "R6 look-aside grant",
          grant_o, exp_gr);
    check(mem_inhibit_o == exp_inh, "R10 memory inhibit", mem_inhibit_o, exp_inh);
    check(holds() == exp_hold, "R11 hold kept through done", holds(), exp_hold);
    cfg_legacy = 0; cfg_backoff = 0; cfg_lookthrough = 0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cpu_hit_i = 0; cpu_hitm_i = 0; l2_hit_i = 0;
    check(!done_o && grant_o == 2'b00 && !mem_inhibit_o, "R9 single-cycle done",
          {done_o, grant_o, mem_inhibit_o}, 0);
    check(holds() == 3'b000, "R11 hold released", holds(), 0);
    @(negedge clk);
    @(negedge clk);
    check(holds() == 3'b000 && !snp_strobe_o, "R11 busy request ignored", holds(), 0);
  endtask

  initial begin
    check_reset();
    run_snoop(0, 0, 0, 0, 0, 0, 0, 0, 2'b01, 0); // look-aside miss, address-hold
    run_snoop(0, 1, 0, 1, 1, 0, 1, 0, 2'b01, 1); // look-aside plain hit, back-off, L2 hit
    run_snoop(0, 0, 1, 0, 0, 0, 1, 0, 2'b10, 0); // look-through miss -> exclusive
    run_snoop(0, 1, 1, 1, 0, 0, 0, 0, 2'b10, 0); // look-through miss with invalidate
    run_snoop(0, 0, 1, 0, 1, 0, 0, 0, 2'b01, 0); // look-through hit -> shared
    run_snoop(0, 0, 1, 1, 1, 1, 0, 3, 2'b01, 0); // modified hit, writeback after 3
    run_snoop(1, 0, 0, 1, 1, 1, 1, 0, 2'b01, 1); // legacy, look-aside modified hit
    run_snoop(1, 1, 1, 0, 0, 0, 0, 0, 2'b10, 0); // legacy look-through miss
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule